// File: doc/BRIEF.md
# Product, Quotient and Remainder Execution Unit

This block executes the wide-multiply, divide and remainder group of a 64-bit register machine. A start pulse presents an 8-bit opcode with the destination operand and either a register operand or a 32-bit immediate. The opcode's upper nibble selects one of twelve operations: high or low product words, and signed or unsigned quotients and remainders at 32 or 64 bits. Its lower nibble selects whether the second operand is the immediate, sign-extended to full width, or the register value.

Multiplies and all exceptional cases finish one cycle after start. Divides and remainders use a restoring shift-subtract loop that produces one quotient bit per cycle. Signed division works on magnitudes and corrects the signs at the end. Completion is a one-cycle `done` pulse carrying either a result or an exception code. When an exception is raised, the result equals the destination operand, so the destination register is left unchanged.

Top module: `pqr_unit`

## Requirements
- R1: The opcode low nibble 0x6 selects the immediate form, with `immVal` sign-extended to XLEN bits, and 0xE selects the register form using `srcVal`. An opcode whose low nibble is anything else, or whose high nibble is 0x0, 0x1, 0x2 or 0xA, completes with excCode 3 (illegal) and result equal to `dstVal`.
- R2: High nibble 0x3 returns the upper XLEN bits of the unsigned 2·XLEN-bit product of dst and operand. High nibble 0xB returns the upper XLEN bits of the signed product.
- R3: High nibble 0x9 returns the lower XLEN bits of dst·operand. High nibble 0x8 returns the lower XLEN/2 bits of the product, with the upper half of the result zero.
- R4: Unsigned division at full width: high nibble 0x5 returns the quotient and 0x7 returns the remainder. At half width, 0x4 returns the quotient and 0x6 returns the remainder; these use only the low halves of both operands and return a zero upper half.
- R5: Signed division at full width: high nibble 0xD returns the quotient and 0xF returns the remainder. At half width, 0xC returns the quotient and 0xE returns the remainder, with a zero upper half. Quotients truncate toward zero, and a remainder has the sign of the dividend.
- R6: A divide or remainder whose divisor is zero at the operation width completes with excCode 1, and result equals `dstVal`.
- R7: A signed divide or remainder whose dividend is the most negative value at the operation width and whose divisor is -1 completes with excCode 2, and result equals `dstVal`. Unsigned operations never raise this code.
- R8: Multiplies and all exception cases assert `done` one cycle after the start cycle. Division assert `done` W+2 cycles after the start cycle, where W is the operation width.
- R9: `done` is a one-cycle pulse per accepted operation. `excCode` is 0 whenever `done` is low. `result` changes only when `done` rises.
- R10: `busy` is high from the cycle after a division is accepted until it completes, and low while `done` is high. A start pulse while `busy` is high is ignored.
- R11: After reset, `done`, `busy`, `excCode` and `result` are all zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Operation request, sampled while not busy |
| opcode | input | 8 | Operation (high nibble) and operand form (low nibble) |
| dstVal | input | XLEN | Destination operand, also the dividend or multiplicand |
| srcVal | input | XLEN | Register operand |
| immVal | input | XLEN/2 | Immediate operand, sign-extended before use |
| done | output | 1 | One-cycle completion pulse |
| result | output | XLEN | Result, valid when done is high |
| excCode | output | 2 | 0 none, 1 divide by zero, 2 signed overflow, 3 illegal opcode |
| busy | output | 1 | Division in progress |

## Verification
A corrupted iteration counter shows up at the ports as `done` arriving too early or too late. The latency check catches this on the first division of each width. A wrong remainder or quotient bit shows up in `result`, or a wrong sign correction in the signed results. Because there is no shared state between operations, each error appears in the very operation that caused it. Exception misdecoding shows up as a nonzero `excCode`, or as a result other than the unchanged destination, one cycle after start. Near-exhaustive operand sweeps with 8-bit words and boundary values such as 0, -1 and the most negative value at each width expose these errors quickly.

// File: rtl/pqr_pkg.sv
package pqr_pkg;

  typedef enum logic [1:0] {
    EXC_NONE     = 2'd0,
    EXC_DIVZERO  = 2'd1,
    EXC_OVERFLOW = 2'd2,
    EXC_ILLEGAL  = 2'd3
  } excCode_e;

  typedef enum logic [2:0] {
    K_UHMUL, K_LMUL, K_SHMUL, K_UDIV, K_UREM, K_SDIV, K_SREM, K_NONE
  } opKind_e;

  typedef enum logic [1:0] {
    SEL_DST, SEL_MUL, SEL_DIV
  } resSel_e;

  typedef struct packed {
    logic    legal;
    opKind_e kind;
    logic    is32;
    logic    useImm;
  } opInfo_t;

  typedef struct packed {
    logic    load;
    logic    step;
    logic    finish;
    resSel_e resSel;
  } ctrlStrobe_t;

  function automatic opInfo_t decodeOp(input logic [7:0] op);
    opInfo_t info;
    info.kind = K_NONE;
    info.is32 = 1'b0;
    unique case (op[7:4])
      4'h3: info.kind = K_UHMUL;
      4'h4: begin info.kind = K_UDIV; info.is32 = 1'b1; end
      4'h5: info.kind = K_UDIV;
      4'h6: begin info.kind = K_UREM; info.is32 = 1'b1; end
      4'h7: info.kind = K_UREM;
      4'h8: begin info.kind = K_LMUL; info.is32 = 1'b1; end
      4'h9: info.kind = K_LMUL;
      4'hB: info.kind = K_SHMUL;
      4'hC: begin info.kind = K_SDIV; info.is32 = 1'b1; end
      4'hD: info.kind = K_SDIV;
      4'hE: begin info.kind = K_SREM; info.is32 = 1'b1; end
      4'hF: info.kind = K_SREM;
      default: info.kind = K_NONE;
    endcase
    info.useImm = (op[3:0] == 4'h6);
    info.legal  = (info.kind != K_NONE) && (op[3:0] == 4'h6 || op[3:0] == 4'hE);
    return info;
  endfunction

  function automatic logic isMulKind(input opKind_e k);
    return (k == K_UHMUL) || (k == K_LMUL) || (k == K_SHMUL);
  endfunction

  function automatic logic isSignedDiv(input opKind_e k);
    return (k == K_SDIV) || (k == K_SREM);
  endfunction

  function automatic logic isRemKind(input opKind_e k);
    return (k == K_UREM) || (k == K_SREM);
  endfunction

endpackage

// File: rtl/pqr_ctrl.sv
module pqr_ctrl
  import pqr_pkg::*;
#(
  parameter int XLEN = 64
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        start,
  input  opInfo_t     info,
  input  logic        divZero,
  input  logic        divOvf,
  output ctrlStrobe_t strobe,
  output logic        done,
  output excCode_e    excOut,
  output logic        busy
);
  localparam int HALF = XLEN / 2;
  localparam int CW   = $clog2(XLEN);

  typedef enum logic [1:0] {ST_IDLE, ST_RUN, ST_FIX} state_e;

  state_e   state, stateNext;
  excCode_e excNext;
  logic [CW-1:0] iterCnt;
  logic [CW-1:0] lastCnt;
  logic          is32Held;

  assign lastCnt = is32Held ? CW'(HALF - 1) : CW'(XLEN - 1);

  always_comb begin
    strobe.load   = 1'b0;
    strobe.step   = 1'b0;
    strobe.finish = 1'b0;
    strobe.resSel = SEL_DST;
    excNext       = EXC_NONE;
    stateNext     = state;
    unique case (state)
      ST_IDLE: begin
        if (start) begin
          if (!info.legal) begin
            strobe.finish = 1'b1;
            excNext       = EXC_ILLEGAL;
          end else if (isMulKind(info.kind)) begin
            strobe.finish = 1'b1;
            strobe.resSel = SEL_MUL;
          end else if (divZero) begin
            strobe.finish = 1'b1;
            excNext       = EXC_DIVZERO;
          end else if (divOvf) begin
            strobe.finish = 1'b1;
            excNext       = EXC_OVERFLOW;
          end else begin
            strobe.load = 1'b1;
            stateNext   = ST_RUN;
          end
        end
      end
      ST_RUN: begin
        strobe.step = 1'b1;
        if (iterCnt == lastCnt) stateNext = ST_FIX;
      end
      ST_FIX: begin
        strobe.finish = 1'b1;
        strobe.resSel = SEL_DIV;
        stateNext     = ST_IDLE;
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      iterCnt  <= '0;
      is32Held <= 1'b0;
      done     <= 1'b0;
      excOut   <= EXC_NONE;
    end else begin
      state  <= stateNext;
      done   <= strobe.finish;
      excOut <= excNext;
      if (strobe.load) begin
        iterCnt  <= '0;
        is32Held <= info.is32;
      end else if (strobe.step) begin
        iterCnt <= iterCnt + 1'b1;
      end
    end
  end

  assign busy = (state != ST_IDLE);

endmodule

// File: rtl/pqr_dpath.sv
module pqr_dpath
  import pqr_pkg::*;
#(
  parameter int XLEN = 64
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobe_t       strobe,
  input  opInfo_t           info,
  input  logic [XLEN-1:0]   dstVal,
  input  logic [XLEN-1:0]   srcVal,
  input  logic [XLEN/2-1:0] immVal,
  output logic              divZero,
  output logic              divOvf,
  output logic [XLEN-1:0]   result
);
  localparam int HALF = XLEN / 2;
  localparam int PW   = 2 * XLEN;

  // operand selection
  logic [XLEN-1:0] operand;
  assign operand = info.useImm ? {{HALF{immVal[HALF-1]}}, immVal} : srcVal;

  logic [HALF-1:0] aLow, bLow;
  assign aLow = dstVal[HALF-1:0];
  assign bLow = operand[HALF-1:0];

  logic signedDiv;
  assign signedDiv = isSignedDiv(info.kind);

  // exception detection at operation width
  logic aIsMin, bIsMinusOne;
  always_comb begin
    if (info.is32) begin
      divZero     = (bLow == '0);
      aIsMin      = (aLow == {1'b1, {(HALF-1){1'b0}}});
      bIsMinusOne = (bLow == '1);
    end else begin
      divZero     = (operand == '0);
      aIsMin      = (dstVal == {1'b1, {(XLEN-1){1'b0}}});
      bIsMinusOne = (operand == '1);
    end
    divOvf = signedDiv && aIsMin && bIsMinusOne;
  end

  // single-cycle product
  logic [PW-1:0] aExt, bExt, prod;
  logic [XLEN-1:0] mulRes;
  always_comb begin
    if (info.kind == K_SHMUL) begin
      aExt = {{XLEN{dstVal[XLEN-1]}}, dstVal};
      bExt = {{XLEN{operand[XLEN-1]}}, operand};
    end else begin
      aExt = {{XLEN{1'b0}}, dstVal};
      bExt = {{XLEN{1'b0}}, operand};
    end
    prod = aExt * bExt;
    if (info.kind == K_LMUL)
      mulRes = info.is32 ? {{HALF{1'b0}}, prod[HALF-1:0]} : prod[XLEN-1:0];
    else
      mulRes = prod[PW-1:XLEN];
  end

  // magnitudes for the restoring divider
  logic aNeg, bNeg;
  logic [XLEN-1:0] aMag, bMag;
  always_comb begin
    if (info.is32) begin
      aNeg = signedDiv && aLow[HALF-1];
      bNeg = signedDiv && bLow[HALF-1];
      aMag = {{HALF{1'b0}}, (aNeg ? (~aLow + 1'b1) : aLow)};
      bMag = {{HALF{1'b0}}, (bNeg ? (~bLow + 1'b1) : bLow)};
    end else begin
      aNeg = signedDiv && dstVal[XLEN-1];
      bNeg = signedDiv && operand[XLEN-1];
      aMag = aNeg ? (~dstVal + 1'b1) : dstVal;
      bMag = bNeg ? (~operand + 1'b1) : operand;
    end
  end

  logic [XLEN-1:0] quoReg, remReg, dvsReg;
  logic            negQuo, negRem, wantRem, half32;

  logic [XLEN:0] trial, diff;
  assign trial = {remReg, quoReg[XLEN-1]};
  assign diff  = trial - {1'b0, dvsReg};

  always_ff @(posedge clk) begin
    if (!rstN) begin
      quoReg  <= '0;
      remReg  <= '0;
      dvsReg  <= '0;
      negQuo  <= 1'b0;
      negRem  <= 1'b0;
      wantRem <= 1'b0;
      half32  <= 1'b0;
    end else if (strobe.load) begin
      // half-width dividends start in the upper half so only HALF steps are needed
      quoReg  <= info.is32 ? {aMag[HALF-1:0], {HALF{1'b0}}} : aMag;
      remReg  <= '0;
      dvsReg  <= bMag;
      negQuo  <= aNeg ^ bNeg;
      negRem  <= aNeg;
      wantRem <= isRemKind(info.kind);
      half32  <= info.is32;
    end else if (strobe.step) begin
      if (!diff[XLEN]) begin
        remReg <= diff[XLEN-1:0];
        quoReg <= {quoReg[XLEN-2:0], 1'b1};
      end else begin
        remReg <= trial[XLEN-1:0];
        quoReg <= {quoReg[XLEN-2:0], 1'b0};
      end
    end
  end

  // sign correction and width masking
  logic [XLEN-1:0] quoMag, quoFix, remFix, divPick, divRes;
  always_comb begin
    quoMag  = half32 ? {{HALF{1'b0}}, quoReg[HALF-1:0]} : quoReg;
    quoFix  = negQuo ? (~quoMag + 1'b1) : quoMag;
    remFix  = negRem ? (~remReg + 1'b1) : remReg;
    divPick = wantRem ? remFix : quoFix;
    divRes  = half32 ? {{HALF{1'b0}}, divPick[HALF-1:0]} : divPick;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      result <= '0;
    end else if (strobe.finish) begin
      unique case (strobe.resSel)
        SEL_MUL: result <= mulRes;
        SEL_DIV: result <= divRes;
        default: result <= dstVal;
      endcase
    end
  end

endmodule

// File: rtl/pqr_unit.sv
module pqr_unit
  import pqr_pkg::*;
#(
  parameter int XLEN = 64
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic [7:0]        opcode,
  input  logic [XLEN-1:0]   dstVal,
  input  logic [XLEN-1:0]   srcVal,
  input  logic [XLEN/2-1:0] immVal,
  output logic              done,
  output logic [XLEN-1:0]   result,
  output logic [1:0]        excCode,
  output logic              busy
);
  opInfo_t     info;
  ctrlStrobe_t strobe;
  logic        divZero, divOvf;
  excCode_e    excE;

  assign info    = decodeOp(opcode);
  assign excCode = excE;

  pqr_ctrl #(.XLEN(XLEN)) u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .start   (start),
    .info    (info),
    .divZero (divZero),
    .divOvf  (divOvf),
    .strobe  (strobe),
    .done    (done),
    .excOut  (excE),
    .busy    (busy)
  );

  pqr_dpath #(.XLEN(XLEN)) u_dpath (
    .clk     (clk),
    .rstN    (rstN),
    .strobe  (strobe),
    .info    (info),
    .dstVal  (dstVal),
    .srcVal  (srcVal),
    .immVal  (immVal),
    .divZero (divZero),
    .divOvf  (divOvf),
    .result  (result)
  );

endmodule

// File: rtl/pqr_unit_chk.sv
module pqr_unit_chk #(
  parameter int XLEN = 64
) (
  input logic              clk,
  input logic              rstN,
  input logic              start,
  input logic [7:0]        opcode,
  input logic [XLEN-1:0]   dstVal,
  input logic              done,
  input logic [XLEN-1:0]   result,
  input logic [1:0]        excCode,
  input logic              busy
);

  // R9: an exception code only accompanies completion
  a_r9_exc_with_done: assert property (@(posedge clk) disable iff (!rstN)
    (excCode != 2'd0) |-> done);

  // R9: result register moves only on a completion edge
  a_r9_result_stable: assert property (@(posedge clk) disable iff (!rstN)
    !done |-> $stable(result));

  // R10: busy and done never overlap
  a_r10_busy_not_done: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !busy);

  // R8: an accepted start either completes next cycle or enters the divide loop
  a_r8_accept: assert property (@(posedge clk) disable iff (!rstN)
    (start && !busy) |=> (done || busy));

  // R6: exceptions leave the destination value as the result
  a_r6_exc_keeps_dst: assert property (@(posedge clk) disable iff (!rstN)
    (done && excCode != 2'd0) |-> (result == $past(dstVal)));

  // R7: overflow is raised only for signed divide and remainder
  a_r7_ovf_signed_only: assert property (@(posedge clk) disable iff (!rstN)
    (done && excCode == 2'd2) |-> ($past(opcode[7:4]) >= 4'hC));

endmodule

bind pqr_unit pqr_unit_chk #(.XLEN(XLEN)) u_chk (
  .clk     (clk),
  .rstN    (rstN),
  .start   (start),
  .opcode  (opcode),
  .dstVal  (dstVal),
  .done    (done),
  .result  (result),
  .excCode (excCode),
  .busy    (busy)
);

// File: tb/pqr_unit_tb.sv
module pqr_unit_tb;
  localparam int XL = 8;
  localparam int HL = XL / 2;

  logic          clk = 1'b0;
  logic          rstN;
  logic          start;
  logic [7:0]    opcode;
  logic [XL-1:0] dstVal, srcVal;
  logic [HL-1:0] immVal;
  logic          done, busy;
  logic [XL-1:0] result;
  logic [1:0]    excCode;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  pqr_unit #(.XLEN(XL)) u_dut (
    .clk(clk), .rstN(rstN), .start(start), .opcode(opcode),
    .dstVal(dstVal), .srcVal(srcVal), .immVal(immVal),
    .done(done), .result(result), .excCode(excCode), .busy(busy)
  );

  task automatic check(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic int pickVal(input int k);
    int sp[11] = '{0, 1, 2, 7, 8, 15, 127, 128, 129, 254, 255};
    if (k < 11) return sp[k];
    return (k * 37 + 11) & 255;
  endfunction

  function automatic bit isHalf(input int hi);
    return hi == 4 || hi == 6 || hi == 8 || hi == 12 || hi == 14;
  endfunction

  function automatic string reqOf(input int hi);
    case (hi)
      3, 11:          return "R2";
      8, 9:           return "R3";
      4, 5, 6, 7:     return "R4";
      12, 13, 14, 15: return "R5";
      default:        return "R1";
    endcase
  endfunction

  // reference model: returns exc in [9:8], result in [7:0], latency in [15:10]
  function automatic int model(input int op, input int d, input int s, input int im);
    int hi = (op >> 4) & 15;
    int lo = op & 15;
    int opnd, w, mask, a, b, sa, sb, p, res, exc, lat;
    opnd = (lo == 6) ? ((im & 8) ? (im | 'hF0) : im) : s;
    w = isHalf(hi) ? HL : XL;
    mask = (1 << w) - 1;
    a = d & mask; b = opnd & mask;
    sa = (a >= (1 << (w - 1))) ? a - (1 << w) : a;
    sb = (b >= (1 << (w - 1))) ? b - (1 << w) : b;
    exc = 0; res = d; lat = 1;
    if (!(lo == 6 || lo == 14) || hi <= 2 || hi == 10) exc = 3;
    else if (hi == 3) res = (d * opnd) >> 8;
    else if (hi == 11) begin
      p = ((d >= 128) ? d - 256 : d) * ((opnd >= 128) ? opnd - 256 : opnd);
      res = (p >>> 8) & 255;
    end
    else if (hi == 8 || hi == 9) res = (a * b) & mask;
    else if (b == 0) exc = 1;
    else if (hi >= 12 && sa == -(1 << (w - 1)) && sb == -1) exc = 2;
    else begin
      lat = w + 2;
      if (hi >= 12) res = ((hi == 12 || hi == 13) ? sa / sb : sa % sb) & mask;
      else          res = ((hi == 4 || hi == 5) ? a / b : a % b) & mask;
    end
    return (lat << 10) | (exc << 8) | (res & 255);
  endfunction

  task automatic runOp(input int op, input int d, input int s, input int im,
                       output int res, output int ex, output int lat);
    @(negedge clk);
    opcode = 8'(op); dstVal = 8'(d); srcVal = 8'(s); immVal = 4'(im); start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    lat = 1;
    while (!done && lat < 100) begin
      @(negedge clk);
      lat++;
    end
    res = int'(result); ex = int'(excCode);
  endtask

  task automatic testOp(input int op, input int d, input int s, input int im);
    int res, ex, lat, m, hi, expEx;
    string rq;
    hi = (op >> 4) & 15;
    m = model(op, d, s, im);
    expEx = (m >> 8) & 3;
    runOp(op, d, s, im, res, ex, lat);
    rq = (expEx == 3) ? "R1" : (expEx == 1) ? "R6" : (expEx == 2) ? "R7" : reqOf(hi);
    if (res != (m & 255) || ex != expEx || lat != (m >> 10)) begin
      $display("  op=%02h dst=%0d src=%0d imm=%0d", op, d, s, im);
    end
    check(rq, "result", res, m & 255);
    check(rq, "excCode", ex, expEx);
    check("R8", "latency", lat, m >> 10);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int his[12] = '{3, 4, 5, 6, 7, 8, 9, 11, 12, 13, 14, 15};
    int res, ex, lat, pulses;
    bit sawBusy;
    rstN = 1'b0; start = 1'b0; opcode = '0; dstVal = '0; srcVal = '0; immVal = '0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R11 reset state
    check("R11", "done", int'(done), 0);
    check("R11", "busy", int'(busy), 0);
    check("R11", "excCode", int'(excCode), 0);
    check("R11", "result", int'(result), 0);

    // register-form sweep over all twelve operations (R2 R3 R4 R5 R6 R7 R8)
    for (int k = 0; k < 12; k++)
      for (int i = 0; i < 24; i++)
        for (int j = 0; j < 24; j++)
          testOp((his[k] << 4) | 14, pickVal(i), pickVal(j), 0);

    // immediate-form sweep, sign-extended 4-bit immediate (R1)
    for (int k = 0; k < 12; k++)
      for (int i = 0; i < 16; i++)
        for (int im = 0; im < 16; im++)
          testOp((his[k] << 4) | 6, pickVal(i), 200, im);

    // illegal opcodes (R1)
    testOp('h06, 77, 3, 1);
    testOp('h1E, 78, 3, 1);
    testOp('h2E, 79, 3, 1);
    testOp('hAE, 80, 3, 1);
    testOp('h3F, 81, 3, 1);
    testOp('h57, 82, 3, 1);
    testOp('hD5, 83, 3, 1);

    // R9 single-cycle done pulse and excCode clear afterwards
    runOp('h5E, 200, 7, 0, res, ex, lat);
    check("R4", "udiv 200/7", res, 28);
    @(negedge clk);
    check("R9", "done after pulse", int'(done), 0);
    check("R9", "excCode after pulse", int'(excCode), 0);
    runOp('h5E, 5, 0, 0, res, ex, lat);
    check("R6", "divzero code", ex, 1);
    @(negedge clk);
    check("R9", "excCode cleared", int'(excCode), 0);

    // R10 start while busy is ignored
    @(negedge clk);
    opcode = 8'hDE; dstVal = 8'd100; srcVal = 8'd7; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    sawBusy = busy;
    @(negedge clk);
    opcode = 8'h9E; dstVal = 8'd3; srcVal = 8'd3; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    pulses = 0;
    res = 0;
    for (int c = 0; c < 20; c++) begin
      if (done) begin pulses++; res = int'(result); end
      @(negedge clk);
    end
    check("R10", "busy during divide", int'(sawBusy), 1);
    check("R10", "done pulses", pulses, 1);
    check("R10", "result of first op", res, 14);
    check("R10", "busy after finish", int'(busy), 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule